// File: doc/BRIEF.md
# Reset Boot Source Selector

This block settles, once per reset, where execution begins after reset is released: at the user code origin (address 0000H) or in the on-chip boot loader. It takes its decision from two sources. The first is a stored boot status byte held in non-volatile memory. The second is a set of three strap pins, whose levels pass through a synchronizer and are captured on the clock edge where reset is released. The decision is latched on that edge and does not change until reset is asserted again.

The block also resolves the effective clock mode. A non-volatile clock override bit, when programmed, forces 6-clock operation. When that bit is erased, a software-controlled register bit chooses between 6-clock and 12-clock operation. The storage of the status byte and the override bit, and the loader firmware, sit outside this block. They reach it only as input levels.

Top module: `boot_start_sel`

## Requirements
- R1: While `rst_in` is high, `boot_valid` and `boot_loader_sel` read 0. In the registered clock-mode variant, `clk6_mode` also reads 0 while `rst_in` is high.
- R2: The release edge is the first rising clock edge that sees `rst_in` low after it was high. On that edge, `boot_valid` becomes 1. If the status byte is 00h and the strap pins do not force boot entry, `boot_loader_sel` becomes 0, which selects user start at 0000H.
- R3: Any nonzero status byte at the release edge gives `boot_loader_sel` = 1. This includes FFh, the default value after an erase.
- R4: Boot entry is forced when the synchronized straps at the release edge show all three of these levels: `strap_fetch_strobe` = 0, `strap_ext_access` = 1 and `strap_addr_latch` = 1. The force applies even when the status byte is 00h. None of the other seven strap combinations forces boot entry.
- R5: While `boot_valid` is 1, changes on the status byte or the straps leave `boot_loader_sel` unchanged.
- R6: Asserting reset again clears `boot_valid`. The next release edge takes a fresh decision from the inputs present at that time.
- R7: When `nv_clk_override` = 1, `clk6_mode` = 1 whatever the value of `sw_clk_double`. In the registered variant the output follows one clock later.
- R8: When `nv_clk_override` = 0, `clk6_mode` equals `sw_clk_double`. With both inputs at 0, their erased and reset defaults, the block selects 12-clock operation (`clk6_mode` = 0).
- R9: A strap level reaches the decision only after SYNC_STAGES rising edges. A force pattern applied SYNC_STAGES edges before the release edge is honoured. The same pattern applied SYNC_STAGES-1 edges before the release edge is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_in | input | 1 | Active-high chip reset request; its release triggers the decision |
| nv_boot_status | input | STATUS_W | Stored boot status byte; 0 selects user code |
| strap_fetch_strobe | input | 1 | Program-fetch strobe pin level (low takes part in the force pattern) |
| strap_ext_access | input | 1 | External-access pin level (high takes part in the force pattern) |
| strap_addr_latch | input | 1 | Address-latch pin level (high takes part in the force pattern) |
| nv_clk_override | input | 1 | Non-volatile clock override, 1 = programmed (forces 6-clock) |
| sw_clk_double | input | 1 | Software clock-mode bit, 1 = 6-clock |
| boot_valid | output | 1 | Decision taken and held since the last release |
| boot_loader_sel | output | 1 | 1 = start in boot loader, 0 = start at 0000H |
| clk6_mode | output | 1 | Effective clock mode, 1 = 6-clock, 0 = 12-clock |

## Verification
The bench builds the block with SYNC_STAGES = 3, STRAP_FORCE_EN = 1 and CLK_MODE_REG = 1. A three-deep synchronizer separates the two sides of the latency boundary in R9 by a clear margin: the force pattern is applied two edges and then three edges ahead of the release edge. Keeping the strap force enabled brings all eight strap combinations within reach against a zero status byte. The registered clock-mode variant makes the one-cycle follow of the override and the software bit observable, together with the value the clock mode is held at during reset.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

   localparam int STRAP_W = 3;

   typedef struct packed {
      logic fetch_strobe;
      logic ext_access;
      logic addr_latch;
   } strap_t;

   // Force pattern: strobe low, external access high, address latch high.
   function automatic logic strap_forces(input strap_t s);
      return (~s.fetch_strobe) & s.ext_access & s.addr_latch;
   endfunction

endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   localparam int LAST = STAGES - 1;

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) stg[0] <= d_in;

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) stg[i] <= stg[i-1];
      end
   endgenerate

   assign d_out = stg[LAST];
endmodule

// File: rtl/bsel_decide.sv
module bsel_decide
   import boot_sel_pkg::*;
#(
   parameter int STATUS_W = 8,
   parameter bit FORCE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_in,
   input  logic [STATUS_W-1:0] status,
   input  strap_t              straps_s,
   output logic                valid_o,
   output logic                loader_o
);
   logic rst_q;
   logic release_edge;
   logic force_hit;
   logic want_loader;

   generate
      if (FORCE_EN) begin : g_force
         assign force_hit = strap_forces(straps_s);
      end else begin : g_noforce
         assign force_hit = 1'b0;
      end
   endgenerate

   assign release_edge = rst_q & ~rst_in;
   assign want_loader  = (|status) | force_hit;

   always_ff @(posedge clk) begin
      rst_q <= rst_in;
      if (rst_in) begin
         valid_o  <= 1'b0;
         loader_o <= 1'b0;
      end else if (release_edge) begin
         valid_o  <= 1'b1;
         loader_o <= want_loader;
      end
   end
endmodule

// File: rtl/bsel_clkmode.sv
module bsel_clkmode #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_in,
   input  logic override_i,
   input  logic sw_bit_i,
   output logic clk6_o
);
   logic mode_next;

   assign mode_next = override_i | sw_bit_i;

   generate
      if (REGISTERED) begin : g_reg
         logic mode_q;
         always_ff @(posedge clk) begin
            if (rst_in) mode_q <= 1'b0;
            else        mode_q <= mode_next;
         end
         assign clk6_o = mode_q;
      end else begin : g_comb
         assign clk6_o = mode_next;
      end
   endgenerate
endmodule

// File: rtl/boot_start_sel.sv
module boot_start_sel
   import boot_sel_pkg::*;
#(
   parameter int STATUS_W       = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit STRAP_FORCE_EN = 1'b1,
   parameter bit CLK_MODE_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_in,
   input  logic [STATUS_W-1:0] nv_boot_status,
   input  logic                strap_fetch_strobe,
   input  logic                strap_ext_access,
   input  logic                strap_addr_latch,
   input  logic                nv_clk_override,
   input  logic                sw_clk_double,
   output logic                boot_valid,
   output logic                boot_loader_sel,
   output logic                clk6_mode
);
   generate
      if (STATUS_W < 1) begin : g_bad_width
         $error("boot_start_sel: STATUS_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("boot_start_sel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   strap_t strap_raw;
   strap_t strap_s;
   logic [STRAP_W-1:0] strap_s_vec;

   assign strap_raw = '{fetch_strobe: strap_fetch_strobe,
                        ext_access:   strap_ext_access,
                        addr_latch:   strap_addr_latch};

   bsel_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .d_in  (strap_raw),
      .d_out (strap_s_vec)
   );
   assign strap_s = strap_t'(strap_s_vec);

   bsel_decide #(.STATUS_W(STATUS_W), .FORCE_EN(STRAP_FORCE_EN)) u_decide (
      .clk      (clk),
      .rst_in   (rst_in),
      .status   (nv_boot_status),
      .straps_s (strap_s),
      .valid_o  (boot_valid),
      .loader_o (boot_loader_sel)
   );

   bsel_clkmode #(.REGISTERED(CLK_MODE_REG)) u_clk (
      .clk        (clk),
      .rst_in     (rst_in),
      .override_i (nv_clk_override),
      .sw_bit_i   (sw_clk_double),
      .clk6_o     (clk6_mode)
   );
endmodule

// File: rtl/boot_start_sel_chk.sv
module boot_start_sel_chk #(
   parameter int STATUS_W       = 8,
   parameter bit STRAP_FORCE_EN = 1'b1,
   parameter bit CLK_MODE_REG   = 1'b1
) (
   input logic                clk,
   input logic                rst_in,
   input logic [STATUS_W-1:0] nv_boot_status,
   input logic [2:0]          strap_s_vec,
   input logic                nv_clk_override,
   input logic                sw_clk_double,
   input logic                boot_valid,
   input logic                boot_loader_sel,
   input logic                clk6_mode
);
   logic seen_q = 1'b0;
   logic rst_prev_q = 1'b0;
   logic pattern_s;

   // bit 2 strobe, bit 1 external access, bit 0 address latch
   assign pattern_s = STRAP_FORCE_EN && strap_s_vec == 3'b011;

   always_ff @(posedge clk) begin
      seen_q     <= 1'b1;
      rst_prev_q <= rst_in;
   end

   // R1: held cleared while reset persists
   always @(negedge clk) begin
      if (seen_q && rst_prev_q && rst_in) begin
         p_reset_clear_r1: assert (!boot_valid && !boot_loader_sel);
      end
   end

   p_user_start_r2: assert property (@(posedge clk) disable iff (rst_in)
      $rose(boot_valid) && $past(nv_boot_status) == '0 && !$past(pattern_s)
      |-> !boot_loader_sel);

   p_status_loader_r3: assert property (@(posedge clk) disable iff (rst_in)
      $rose(boot_valid) && $past(nv_boot_status) != '0 |-> boot_loader_sel);

   p_strap_force_r4: assert property (@(posedge clk) disable iff (rst_in)
      $rose(boot_valid) && $past(pattern_s) |-> boot_loader_sel);

   p_hold_r5: assert property (@(posedge clk) disable iff (rst_in)
      boot_valid |=> boot_valid && $stable(boot_loader_sel));

   generate
      if (CLK_MODE_REG) begin : g_reg_chk
         p_override_r7: assert property (@(posedge clk) disable iff (rst_in)
            nv_clk_override |=> clk6_mode);
         p_sw_select_r8: assert property (@(posedge clk) disable iff (rst_in)
            !nv_clk_override |=> clk6_mode == $past(sw_clk_double));
      end else begin : g_comb_chk
         always @(negedge clk) begin
            p_override_r7: assert (!nv_clk_override || clk6_mode);
            p_sw_select_r8: assert (nv_clk_override || clk6_mode == sw_clk_double);
         end
      end
   endgenerate
endmodule

bind boot_start_sel boot_start_sel_chk #(
   .STATUS_W       (STATUS_W),
   .STRAP_FORCE_EN (STRAP_FORCE_EN),
   .CLK_MODE_REG   (CLK_MODE_REG)
) u_chk (
   .clk             (clk),
   .rst_in          (rst_in),
   .nv_boot_status  (nv_boot_status),
   .strap_s_vec     (strap_s_vec),
   .nv_clk_override (nv_clk_override),
   .sw_clk_double   (sw_clk_double),
   .boot_valid      (boot_valid),
   .boot_loader_sel (boot_loader_sel),
   .clk6_mode       (clk6_mode)
);

// File: tb/sim_boot_start_sel.sv
module sim_boot_start_sel;
   localparam int SYNC = 3;

   logic       clk = 1'b0;
   logic       rst_in = 1'b1;
   logic [7:0] status = 8'hFF;
   logic       s_strobe = 1'b1, s_ext = 1'b0, s_latch = 1'b0;
   logic       fx2 = 1'b0, x2 = 1'b0;
   logic       valid, loader, clk6;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   boot_start_sel #(.STATUS_W(8), .SYNC_STAGES(SYNC),
                    .STRAP_FORCE_EN(1'b1), .CLK_MODE_REG(1'b1)) u0 (
      .clk(clk), .rst_in(rst_in), .nv_boot_status(status),
      .strap_fetch_strobe(s_strobe), .strap_ext_access(s_ext),
      .strap_addr_latch(s_latch), .nv_clk_override(fx2),
      .sw_clk_double(x2), .boot_valid(valid),
      .boot_loader_sel(loader), .clk6_mode(clk6));

   // fields: [11:4] status, [3] strobe, [2] ext access, [1] addr latch, [0] expected loader
   localparam int NV = 10;
   localparam logic [11:0] VEC [NV] = '{
      {8'h00, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'hFF, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'h01, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h80, 1'b1, 1'b1, 1'b1, 1'b1},
      {8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
      {8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
      {8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
      {8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h5A, 1'b0, 1'b1, 1'b1, 1'b1}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reset with given inputs, release, sample one edge after release.
   task automatic boot(input logic [7:0] st, input logic a, input logic b, input logic c);
      @(negedge clk);
      rst_in = 1'b1; status = st; s_strobe = a; s_ext = b; s_latch = c;
      repeat (6) @(negedge clk);
      rst_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic sync_edge(input int n, input logic exp);
      @(negedge clk);
      rst_in = 1'b1; status = 8'h00; s_strobe = 1'b1; s_ext = 1'b1; s_latch = 1'b1;
      repeat (6) @(negedge clk);
      s_strobe = 1'b0;
      repeat (n) @(negedge clk);
      rst_in = 1'b0;
      @(negedge clk);
      check("R9 sync latency", {7'd0, loader}, {7'd0, exp});
   endtask

   initial begin
      // R1: reset state, with the software bit set
      x2 = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 valid in reset", {7'd0, valid}, 8'd0);
      check("R1 loader in reset", {7'd0, loader}, 8'd0);
      check("R1 clk6 in reset", {7'd0, clk6}, 8'd0);
      x2 = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         string tag;
         v = VEC[i];
         if (v[11:4] != 8'h00) tag = "R3 status";
         else if (v[3:1] == 3'b011) tag = "R4 strap force";
         else tag = "R2/R4 user start";
         boot(v[11:4], v[3], v[2], v[1]);
         check("R2 valid after release", {7'd0, valid}, 8'd1);
         check(tag, {7'd0, loader}, {7'd0, v[0]});
      end

      // R5: changes after release have no effect
      boot(8'h00, 1'b1, 1'b1, 1'b1);
      status = 8'hFF; s_strobe = 1'b0;
      repeat (6) @(negedge clk);
      check("R5 hold user", {7'd0, loader}, 8'd0);
      check("R5 valid held", {7'd0, valid}, 8'd1);
      boot(8'h33, 1'b1, 1'b1, 1'b1);
      status = 8'h00; s_strobe = 1'b1;
      repeat (6) @(negedge clk);
      check("R5 hold loader", {7'd0, loader}, 8'd1);

      // R6: new reset clears and re-decides
      @(negedge clk);
      rst_in = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 valid cleared", {7'd0, valid}, 8'd0);
      status = 8'h00; s_strobe = 1'b1; s_ext = 1'b0; s_latch = 1'b0;
      repeat (4) @(negedge clk);
      rst_in = 1'b0;
      @(negedge clk);
      check("R6 fresh decision", {7'd0, loader}, 8'd0);
      check("R6 valid again", {7'd0, valid}, 8'd1);

      // R9: synchronizer boundary
      sync_edge(SYNC - 1, 1'b0);
      sync_edge(SYNC, 1'b1);

      // R7 / R8: clock mode, one edge of latency
      fx2 = 1'b0; x2 = 1'b0; @(negedge clk);
      check("R8 erased default 12-clk", {7'd0, clk6}, 8'd0);
      fx2 = 1'b0; x2 = 1'b1; @(negedge clk);
      check("R8 sw selects 6-clk", {7'd0, clk6}, 8'd1);
      fx2 = 1'b1; x2 = 1'b0; @(negedge clk);
      check("R7 override forces 6-clk", {7'd0, clk6}, 8'd1);
      fx2 = 1'b1; x2 = 1'b1; @(negedge clk);
      check("R7 override with sw set", {7'd0, clk6}, 8'd1);
      fx2 = 1'b0; x2 = 1'b0; @(negedge clk);
      check("R8 back to 12-clk", {7'd0, clk6}, 8'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all-requirements actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule